// File: doc/BRIEF.md
# Commit-Time Memory Dependence Tracker

This block watches the stream of memory operations as they commit and discovers which static instructions touch the same data word. It holds a small fully associative table keyed by word address. Each live entry remembers the instruction address (PC) of the operation that claimed the word and whether that operation was a load or a store. Every commit looks up its address. A load that finds an entry yields a dependence report one cycle later. The report names the recorded instruction as source and the committing load as sink, and it is tagged as read-after-write when a store owns the entry or read-after-read when a load owns it.

The ownership policy keeps the source as the oldest producer of the value. A store always takes the word for itself, overwriting whatever owner was there. A load takes ownership only when nothing owns the word yet. Later loads therefore link to the last store or, if no store has been seen, to the first load. Loads and stores share one pool of entries. When the pool is full, a missing operation displaces the least recently used entry. Any commit that hits an entry makes that entry the most recently used. At most one commit is accepted per cycle.

A downstream predictor consumes the reports to learn which pairs of instructions communicate through memory. This block does no prediction and forwards no values.

Top module: `mdep_track`

## Requirements
- R1: After reset the table is empty and `rpt_valid` is 0. The first commit of any address, load or store, produces no report.
- R2: A committed load whose word is owned by a store raises `rpt_valid` in the following cycle, with `rpt_is_raw`=1, `rpt_src_pc` equal to that store's PC and `rpt_sink_pc` equal to the load's PC.
- R3: A committed load whose word is owned by a load raises a report in the following cycle, with `rpt_is_raw`=0 and `rpt_src_pc` equal to the owning load's PC.
- R4: A load that hits leaves the owner unchanged, so every later load of the same word still names the earliest load as source while no store intervenes.
- R5: A committed store always becomes the owner of its word, replacing a load or an older store. Each word has at most one entry.
- R6: Committed stores never produce a report, and cycles with `cmt_valid`=0 change nothing and produce no report.
- R7: Matching uses the full word address. Neighbouring addresses are tracked independently.
- R8: When all entries are in use, a missing commit evicts the least recently used entry, and a later load of the evicted word misses and produces no report.
- R9: A hit by a load or a store refreshes the recency of the entry it hits.
- R10: A report is a single-cycle pulse. `rpt_sink_pc` is the PC presented with the commit one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmt_valid | input | 1 | A memory operation commits this cycle |
| cmt_is_store | input | 1 | 1 = store, 0 = load |
| cmt_addr | input | ADDR_W | Word address of the committing operation |
| cmt_pc | input | PC_W | Instruction address of the committing operation |
| rpt_valid | output | 1 | Dependence report pulse |
| rpt_src_pc | output | PC_W | PC of the recorded owner (source) |
| rpt_sink_pc | output | PC_W | PC of the load that hit (sink) |
| rpt_is_raw | output | 1 | 1 = read-after-write, 0 = read-after-read |

## Verification
The hardest state to reach from the ports is a full table whose recency order has been disturbed by hits. Only there does the choice of victim become visible, and only through a later load that misses where it would otherwise have hit. The bench builds the design with eight entries. A directed sequence fills the table, refreshes the oldest word, adds one new word, and then probes both the evicted word and the refreshed one. A long random phase then draws addresses from a pool slightly larger than the table and mixes stores with loads, so that evictions, store takeovers and repeated read-after-read hits keep interleaving.

// File: rtl/mdep_pkg.sv
`timescale 1ns/1ps
package mdep_pkg;
  typedef enum logic {DEP_RAR = 1'b0, DEP_RAW = 1'b1} dep_kind_t;
  typedef enum logic {OWN_LOAD = 1'b0, OWN_STORE = 1'b1} owner_t;
endpackage

// File: rtl/mdep_match.sv
`timescale 1ns/1ps
module mdep_match #(
  parameter int ENTRIES = 128,
  parameter int ADDR_W  = 30,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] ent_vld,
  input  logic [ADDR_W-1:0]  ent_addr [ENTRIES],
  input  logic [ADDR_W-1:0]  key,
  output logic [ENTRIES-1:0] match_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = ent_vld[g] && (ent_addr[g] == key);
  end

  assign hit = |match_vec;

  // At most one bit is set, so OR-ing the indices encodes it.
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match_vec[i]) hit_idx = hit_idx | IDX_W'(i);
  end
endmodule

// File: rtl/mdep_lru.sv
`timescale 1ns/1ps
module mdep_lru #(
  parameter int ENTRIES = 128,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  // Ages always form a permutation of 0..ENTRIES-1. Unused entries keep the
  // highest ages, so the oldest entry is a free one whenever one exists.
  logic [IDX_W-1:0]   age [ENTRIES];
  logic [ENTRIES-1:0] oldest_vec;
  logic [IDX_W-1:0]   touched_age;

  assign touched_age = age[touch_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)   age[i] <= '0;
        else if (age[i] < touched_age) age[i] <= age[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign oldest_vec[g] = (age[g] == OLDEST);
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (oldest_vec[i]) victim_idx = victim_idx | IDX_W'(i);
  end

  // R8
  single_victim_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest_vec) == 1);

  // R9
  victim_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (touch && touch_idx == victim_idx) |=> (victim_idx != $past(victim_idx)));
endmodule

// File: rtl/mdep_track.sv
`timescale 1ns/1ps
module mdep_track #(
  parameter int ENTRIES = 128,
  parameter int ADDR_W  = 30,
  parameter int PC_W    = 30,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmt_valid,
  input  logic              cmt_is_store,
  input  logic [ADDR_W-1:0] cmt_addr,
  input  logic [PC_W-1:0]   cmt_pc,
  output logic              rpt_valid,
  output logic [PC_W-1:0]   rpt_src_pc,
  output logic [PC_W-1:0]   rpt_sink_pc,
  output logic              rpt_is_raw
);
  import mdep_pkg::*;

  logic [ENTRIES-1:0] ent_vld;
  owner_t             ent_own  [ENTRIES];
  logic [ADDR_W-1:0]  ent_addr [ENTRIES];
  logic [PC_W-1:0]    ent_pc   [ENTRIES];

  logic [ENTRIES-1:0] match_vec;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   slot;
  logic               wr_en;
  logic               ld_hit;

  mdep_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) match_i (
    .ent_vld  (ent_vld),
    .ent_addr (ent_addr),
    .key      (cmt_addr),
    .match_vec(match_vec),
    .hit      (hit),
    .hit_idx  (hit_idx)
  );

  mdep_lru #(.ENTRIES(ENTRIES)) lru_i (
    .clk       (clk),
    .rst       (rst),
    .touch     (cmt_valid),
    .touch_idx (slot),
    .victim_idx(victim_idx)
  );

  // A store claims its word every time. A load claims only a word with no owner.
  assign slot   = hit ? hit_idx : victim_idx;
  assign wr_en  = cmt_valid && (cmt_is_store || !hit);
  assign ld_hit = cmt_valid && !cmt_is_store && hit;

  always_ff @(posedge clk) begin
    if (rst) ent_vld <= '0;
    else if (wr_en) ent_vld[slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_addr[slot] <= cmt_addr;
      ent_pc[slot]   <= cmt_pc;
      ent_own[slot]  <= cmt_is_store ? OWN_STORE : OWN_LOAD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rpt_valid   <= 1'b0;
      rpt_src_pc  <= '0;
      rpt_sink_pc <= '0;
      rpt_is_raw  <= 1'b0;
    end else begin
      rpt_valid <= ld_hit;
      if (ld_hit) begin
        rpt_src_pc  <= ent_pc[hit_idx];
        rpt_sink_pc <= cmt_pc;
        rpt_is_raw  <= (ent_own[hit_idx] == OWN_STORE) ? logic'(DEP_RAW) : logic'(DEP_RAR);
      end
    end
  end

  // R5
  unique_word_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  // R6
  store_silent_chk: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |-> $past(cmt_valid && !cmt_is_store));

  // R10
  sink_pc_chk: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |-> (rpt_sink_pc == $past(cmt_pc)));

  // R2
  raw_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (cmt_valid && !cmt_is_store && $past(cmt_valid && cmt_is_store) &&
     cmt_addr == $past(cmt_addr))
    |=> (rpt_valid && rpt_is_raw && rpt_src_pc == $past(cmt_pc, 2)));
endmodule

// File: tb/mdep_track_tb.sv
`timescale 1ns/1ps
module mdep_track_tb_top;
  localparam int N  = 8;
  localparam int AW = 30;
  localparam int PW = 30;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmt_valid = 1'b0;
  logic          cmt_is_store = 1'b0;
  logic [AW-1:0] cmt_addr = '0;
  logic [PW-1:0] cmt_pc = '0;
  logic          rpt_valid;
  logic [PW-1:0] rpt_src_pc;
  logic [PW-1:0] rpt_sink_pc;
  logic          rpt_is_raw;

  always #4 clk = ~clk;

  mdep_track #(.ENTRIES(N), .ADDR_W(AW), .PC_W(PW)) dut_i (
    .clk(clk), .rst(rst), .cmt_valid(cmt_valid), .cmt_is_store(cmt_is_store),
    .cmt_addr(cmt_addr), .cmt_pc(cmt_pc), .rpt_valid(rpt_valid),
    .rpt_src_pc(rpt_src_pc), .rpt_sink_pc(rpt_sink_pc), .rpt_is_raw(rpt_is_raw)
  );

  // Reference model: valid, owner kind, address, PC and last-use stamp per entry.
  bit            m_vld [N];
  bit            m_st  [N];
  logic [AW-1:0] m_addr[N];
  logic [PW-1:0] m_pc  [N];
  int            m_stamp[N];
  int            now;

  bit            exp_v;
  logic [PW-1:0] exp_src, exp_sink;
  bit            exp_raw;
  string         exp_tag;
  int            checks, fails;
  bit            done;

  function automatic int m_find(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_addr[i] == a) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    int v = 0;
    for (int i = 0; i < N; i++) if (!m_vld[i]) return i;
    for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[v]) v = i;
    return v;
  endfunction

  task automatic check_out();
    checks++;
    if (rpt_valid !== exp_v) begin
      fails++;
      $display("FAIL %s: rpt_valid=%0b expected %0b", exp_tag, rpt_valid, exp_v);
    end else if (exp_v && (rpt_src_pc !== exp_src || rpt_sink_pc !== exp_sink ||
                           rpt_is_raw !== exp_raw)) begin
      fails++;
      $display("FAIL %s: src=%h sink=%h raw=%0b expected src=%h sink=%h raw=%0b",
               exp_tag, rpt_src_pc, rpt_sink_pc, rpt_is_raw, exp_src, exp_sink, exp_raw);
    end
  endtask

  // Checks the previous commit's report, then presents a new commit.
  task automatic commit(input bit v, input bit st, input logic [AW-1:0] a,
                        input logic [PW-1:0] pc, input string tag);
    int h, s;
    @(negedge clk);
    check_out();
    cmt_valid = v; cmt_is_store = st; cmt_addr = a; cmt_pc = pc;
    exp_v = 1'b0; exp_tag = tag;
    if (v) begin
      now++;
      h = m_find(a);
      if (h >= 0 && !st) begin
        exp_v = 1'b1; exp_src = m_pc[h]; exp_sink = pc; exp_raw = m_st[h];
      end
      s = (h >= 0) ? h : m_victim();
      if (st || h < 0) begin
        m_vld[s] = 1'b1; m_st[s] = st; m_addr[s] = a; m_pc[s] = pc;
      end
      m_stamp[s] = now;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmt_valid = 1'b0;
    repeat (3) @(posedge clk);
    for (int i = 0; i < N; i++) begin m_vld[i] = 1'b0; m_stamp[i] = 0; end
    now = 0;
    @(negedge clk);
    rst = 1'b0;
    exp_v = 1'b0; exp_tag = "R1 reset";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    checks = 0; fails = 0; done = 1'b0;
    do_reset();
    // R1: first load of a word is silent
    commit(1, 0, 30'd5, 30'h100, "R1 first load");
    // R3: second load links to the first
    commit(1, 0, 30'd5, 30'h104, "R3 rar");
    // R4: third load still names the earliest load
    commit(1, 0, 30'd5, 30'h108, "R4 earliest");
    // R6: store is silent
    commit(1, 1, 30'd5, 30'h200, "R6 store silent");
    // R2: load after store reports read-after-write
    commit(1, 0, 30'd5, 30'h10c, "R2 raw");
    // R5: a newer store takes the word over
    commit(1, 1, 30'd5, 30'h204, "R5 store2");
    commit(1, 0, 30'd5, 30'h110, "R5 newest store");
    // R7: neighbouring word is independent
    commit(1, 0, 30'd4, 30'h300, "R7 neighbour");
    commit(1, 0, 30'd6, 30'h304, "R7 neighbour");
    // R6: idle cycle with store-looking inputs does nothing
    commit(0, 1, 30'd5, 30'h400, "R6 idle");
    commit(1, 0, 30'd5, 30'h114, "R6 after idle");
    // R10: pulse ends after one cycle
    commit(0, 0, 30'd5, 30'h0, "R10 pulse");
    commit(0, 0, 30'd5, 30'h0, "R10 quiet");

    do_reset();
    for (int i = 0; i < N; i++) commit(1, 0, AW'(100 + i), PW'(16'h500 + i), "R8 fill");
    // R9: refresh the oldest word with a store hit
    commit(1, 1, 30'd100, 30'h600, "R9 refresh");
    // R8: a new word evicts word 101, the least recently used
    commit(1, 0, 30'd108, 30'h601, "R8 evict");
    commit(1, 0, 30'd101, 30'h602, "R8 evicted miss");
    commit(1, 0, 30'd100, 30'h603, "R9 survivor");
    commit(0, 0, 30'd0, 30'h0, "R9 survivor");

    do_reset();
    for (int k = 0; k < 4000; k++) begin
      bit v  = ($urandom % 100) < 85;
      bit st = ($urandom % 100) < 30;
      logic [AW-1:0] a  = AW'($urandom % 12);
      logic [PW-1:0] pc = PW'($urandom);
      commit(v, st, a, pc, "R8 random");
    end
    commit(0, 0, 30'd0, 30'h0, "R10 tail");
    @(negedge clk);
    check_out();

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule